// File: doc/BRIEF.md
# Lockable Watchdog with Mode-Preserving Reset

This block is a watchdog for a small processor. Software turns it on with a write to a control byte. From then on it counts clock cycles through a prescaler and a terminal counter. Software must service it before the count runs out, and a service is a write of zero to one bit at a fixed address. If the count runs out first, the block drives an internal reset pulse of fixed length back to the processor.

Software can turn the watchdog on but never off. Only a reset clears the enable: either the external power-on reset or the watchdog's own pulse.

The block also keeps the device operating mode in a latch. The latch samples a mode pin only during the power-on reset. A watchdog reset leaves the latch alone, so the processor restarts in the mode it was running in.

Top module: `cop_watchdog`

## Requirements
- R1: A bus write to address 0xFFF0 with data bit 0 at 0, made while the watchdog is enabled, restarts the timeout. The next reset pulse then begins PRESCALE*TERMINAL cycles after the clock edge that took the write.
- R2: Once enabled, the watchdog asserts `cop_rst_o` exactly PRESCALE*TERMINAL clock edges after the edge that set the enable, provided no service write arrives in between.
- R3: After a power-on reset or a watchdog pulse, the watchdog is disabled and its count is zero. Reading address 0x1C then returns 0.
- R4: A bus write to address 0x1C with data bit 2 at 1 enables the watchdog. A write to 0x1C with bit 2 at 0 does not enable it, whatever the other bits hold.
- R5: Once the watchdog is enabled, writing 0 to bit 2 at 0x1C has no effect. The enable stays set and the timeout still falls on its original cycle.
- R6: A watchdog reset pulse never changes `mode_o`, even when `mode_pin` has changed since power-on.
- R7: On every clock edge where `por_i` is high, `mode_o` takes the value of `mode_pin`. At all other times `mode_o` holds its value.
- R8: A reset pulse is high for exactly PULSE_LEN cycles. It clears the enable, so no further pulse follows unless software enables the watchdog again.
- R9: A write to 0xFFF0 with bit 0 at 1 does not service the watchdog. A service write made while the watchdog is disabled neither enables it nor causes a reset.
- R10: While `bus_addr` is 0x1C, `bus_rdata` shows the enable in bit 2, with every other bit at 0. For any other address, `bus_rdata` is 0.
- R11: If a service write lands on the same edge on which the terminal count would be reached, the service wins. No pulse is issued, and a full new timeout begins at that edge.
- R12: While the watchdog is disabled, `cop_rst_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | External power-on reset, synchronous, active high |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; shows the control byte at 0x1C |
| mode_pin | input | MODE_W | Mode strap pin, sampled during power-on reset |
| mode_o | output | MODE_W | Latched operating mode |
| cop_rst_o | output | 1 | Internal reset pulse raised by the watchdog |

## Verification
The timeout is run under four patterns, each checked at the exact edge where the pulse should rise.
- An undisturbed run sets the baseline count.
- A run with a mid-window service shows that the count restarts from the service edge rather than continuing.
- A run with a write of bit 0 at 1 shows that the data bit, not just the address, decides a service.
- A run with a service on the terminal edge itself checks that the service wins.

An attempt to clear the enable is checked against both the readback and the original timeout cycle. A mode pin that changes between power-on and a watchdog pulse shows which kind of reset reloads the mode latch.

// File: rtl/cop_pkg.sv
package cop_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] SVC_ADDR  = 16'hFFF0;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 16'h001C;
    localparam int SVC_BIT = 0;
    localparam int EN_BIT  = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } cop_bus_t;

    typedef struct packed {
        logic svc;
        logic en_set;
    } cop_cmd_t;

    typedef enum logic {
        PULSE_IDLE = 1'b0,
        PULSE_ON   = 1'b1
    } pulse_st_e;

    function automatic cop_cmd_t decode_write(input cop_bus_t b);
        cop_cmd_t c;
        c.svc    = b.wr && (b.addr == SVC_ADDR)  && !b.wdata[SVC_BIT];
        c.en_set = b.wr && (b.addr == CTRL_ADDR) &&  b.wdata[EN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_view(input logic en);
        logic [DATA_W-1:0] v;
        v = '0;
        v[EN_BIT] = en;
        return v;
    endfunction

endpackage

// File: rtl/cop_bus_decode.sv
module cop_bus_decode
    import cop_pkg::*;
(
    input  cop_bus_t          bus,
    input  logic              en,
    output cop_cmd_t          cmd,
    output logic [DATA_W-1:0] rdata
);
    logic unused_wdata;

    always_comb begin
        cmd   = decode_write(bus);
        rdata = (bus.addr == CTRL_ADDR) ? ctrl_view(en) : '0;
    end

    assign unused_wdata = ^bus.wdata;

endmodule

// File: rtl/cop_timebase.sv
module cop_timebase #(
    parameter int PRESCALE = 64,
    parameter int TERMINAL = 1024
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    input  logic svc,
    output logic expire
);
    localparam int CNT_W = (TERMINAL > 1) ? $clog2(TERMINAL) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TERMINAL - 1);

    logic             tick;
    logic             hold;
    logic [CNT_W-1:0] cnt_q;
    logic             at_term;

    assign hold = clr || svc || !run;

    generate
        if (PRESCALE == 1) begin : g_no_pre
            assign tick = 1'b1;
        end else begin : g_pre
            localparam int PRE_W = $clog2(PRESCALE);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (hold)                 pre_q <= '0;
                else if (pre_q == PRE_LAST) pre_q <= '0;
                else                      pre_q <= pre_q + 1'b1;
            end

            assign tick = (pre_q == PRE_LAST);
        end
    endgenerate

    assign at_term = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (hold)         cnt_q <= '0;
        else if (tick)    cnt_q <= at_term ? '0 : cnt_q + 1'b1;
    end

    // a service in the same cycle suppresses expiry
    assign expire = run && !clr && !svc && tick && at_term;

endmodule

// File: rtl/cop_pulse_gen.sv
module cop_pulse_gen
    import cop_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic por,
    input  logic fire,
    output logic pulse
);
    localparam int PC_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

    pulse_st_e       st_q;
    logic [PC_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (por) begin
            st_q   <= PULSE_IDLE;
            left_q <= '0;
        end else begin
            case (st_q)
                PULSE_IDLE: if (fire) begin
                    st_q   <= PULSE_ON;
                    left_q <= PC_W'(PULSE_LEN - 1);
                end
                PULSE_ON: begin
                    if (left_q == '0) st_q   <= PULSE_IDLE;
                    else              left_q <= left_q - 1'b1;
                end
                default: st_q <= PULSE_IDLE;
            endcase
        end
    end

    assign pulse = (st_q == PULSE_ON);

endmodule

// File: rtl/cop_mode_latch.sv
module cop_mode_latch #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              por,
    input  logic [MODE_W-1:0] pin,
    output logic [MODE_W-1:0] mode
);
    always_ff @(posedge clk) begin
        if (por) mode <= pin;
    end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int PRESCALE  = 64,
    parameter int TERMINAL  = 1024,
    parameter int PULSE_LEN = 4,
    parameter int MODE_W    = 2
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [MODE_W-1:0] mode_pin,
    output logic [MODE_W-1:0] mode_o,
    output logic              cop_rst_o
);
    cop_bus_t bus;
    cop_cmd_t cmd;
    logic     en_q;
    logic     rst_any;
    logic     expire;

    assign bus.addr  = bus_addr;
    assign bus.wr    = bus_wr;
    assign bus.wdata = bus_wdata;

    // internal reset: external POR or the watchdog's own pulse
    assign rst_any = por_i || cop_rst_o;

    cop_bus_decode u_dec (
        .bus   (bus),
        .en    (en_q),
        .cmd   (cmd),
        .rdata (bus_rdata)
    );

    // set-only enable: software has no path to clear it
    always_ff @(posedge clk) begin
        if (rst_any)         en_q <= 1'b0;
        else if (cmd.en_set) en_q <= 1'b1;
    end

    cop_timebase #(
        .PRESCALE (PRESCALE),
        .TERMINAL (TERMINAL)
    ) u_tb (
        .clk    (clk),
        .clr    (rst_any),
        .run    (en_q),
        .svc    (cmd.svc),
        .expire (expire)
    );

    cop_pulse_gen #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk   (clk),
        .por   (por_i),
        .fire  (expire),
        .pulse (cop_rst_o)
    );

    cop_mode_latch #(
        .MODE_W (MODE_W)
    ) u_mode (
        .clk  (clk),
        .por  (por_i),
        .pin  (mode_pin),
        .mode (mode_o)
    );

endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
    parameter int PULSE_LEN = 4,
    parameter int MODE_W    = 2
) (
    input logic              clk,
    input logic              por_i,
    input logic [15:0]       bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [MODE_W-1:0] mode_o,
    input logic              cop_rst_o,
    input logic              en_q
);
    int   hi_run;
    logic svc_wr;
    logic en_wr;

    assign svc_wr = bus_wr && (bus_addr == 16'hFFF0) && !bus_wdata[0];
    assign en_wr  = bus_wr && (bus_addr == 16'h001C) &&  bus_wdata[2];

    always_ff @(posedge clk) begin
        if (por_i)          hi_run <= 0;
        else if (cop_rst_o) hi_run <= hi_run + 1;
        else                hi_run <= 0;
    end

    a_r3_pulse_disables: assert property (@(posedge clk) disable iff (por_i)
        cop_rst_o |=> !en_q);

    a_r4_enable_sets: assert property (@(posedge clk) disable iff (por_i)
        (en_wr && !cop_rst_o) |=> en_q);

    a_r5_sticky_enable: assert property (@(posedge clk) disable iff (por_i)
        (en_q && !cop_rst_o) |=> en_q);

    a_r6_mode_held: assert property (@(posedge clk) disable iff (por_i)
        1'b1 |=> $stable(mode_o));

    a_r8_pulse_bound: assert property (@(posedge clk) disable iff (por_i)
        hi_run <= PULSE_LEN);

    a_r11_service_wins: assert property (@(posedge clk) disable iff (por_i)
        (en_q && !cop_rst_o && svc_wr) |=> !cop_rst_o);

    a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (por_i)
        (!en_q && !cop_rst_o) |=> !cop_rst_o);

endmodule

bind cop_watchdog cop_watchdog_chk #(
    .PULSE_LEN (PULSE_LEN),
    .MODE_W    (MODE_W)
) u_chk (
    .clk       (clk),
    .por_i     (por_i),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .mode_o    (mode_o),
    .cop_rst_o (cop_rst_o),
    .en_q      (en_q)
);

// File: tb/sim_cop_watchdog.sv
`timescale 1ns/1ps
module sim_cop_watchdog;
    localparam int PRESCALE  = 3;
    localparam int TERMINAL  = 4;
    localparam int PULSE_LEN = 4;
    localparam int MODE_W    = 2;
    localparam int TMO       = PRESCALE * TERMINAL;

    logic              clk = 1'b0;
    logic              por_i = 1'b1;
    logic [15:0]       bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [MODE_W-1:0] mode_pin = 2'b10;
    logic [MODE_W-1:0] mode_o;
    logic              cop_rst_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2.5 clk = ~clk;

    cop_watchdog #(
        .PRESCALE (PRESCALE), .TERMINAL (TERMINAL),
        .PULSE_LEN (PULSE_LEN), .MODE_W (MODE_W)
    ) u0 (
        .clk (clk), .por_i (por_i), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .mode_pin (mode_pin),
        .mode_o (mode_o), .cop_rst_o (cop_rst_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [15:0] a, output int v);
        bus_addr = a;
        #0.5;
        v = int'(bus_rdata);
        bus_addr = '0;
    endtask

    task automatic do_por(input logic [MODE_W-1:0] pin);
        mode_pin = pin; por_i = 1'b1;
        idle(2);
        por_i = 1'b0;
    endtask

    task automatic t_reset_state;
        int v;
        do_por(2'b10);
        chk("R3 rst low after por", cop_rst_o, 0);
        rd(16'h001C, v); chk("R3 ctrl reads 0 after por", v, 0);
        chk("R7 mode sampled on por", mode_o, 2);
        idle(TMO + 5);
        chk("R12 no pulse while disabled", cop_rst_o, 0);
    endtask

    task automatic t_timeout;
        int v;
        do_por(2'b10);
        wr(16'h001C, 8'h04);
        rd(16'h001C, v); chk("R4 enable readback", v, 4);
        idle(TMO - 1); chk("R2 no pulse before timeout", cop_rst_o, 0);
        idle(1);       chk("R2 pulse at timeout", cop_rst_o, 1);
        idle(PULSE_LEN - 1); chk("R8 pulse still high at last cycle", cop_rst_o, 1);
        idle(1);       chk("R8 pulse ends after PULSE_LEN", cop_rst_o, 0);
        rd(16'h001C, v); chk("R3 disabled after watchdog reset", v, 0);
        idle(TMO + 5); chk("R8 no second pulse", cop_rst_o, 0);
    endtask

    task automatic t_sticky;
        int v;
        do_por(2'b10);
        wr(16'h001C, 8'h04);
        idle(2);
        wr(16'h001C, 8'h00);
        rd(16'h001C, v); chk("R5 enable survives clear attempt", v, 4);
        idle(TMO - 4); chk("R5 no early pulse", cop_rst_o, 0);
        idle(1);       chk("R5 pulse on original cycle", cop_rst_o, 1);
        idle(PULSE_LEN);
    endtask

    task automatic t_service;
        do_por(2'b10);
        wr(16'h001C, 8'h04);
        idle(7);
        wr(16'hFFF0, 8'hFE);
        idle(TMO - 1); chk("R1 serviced count not expired", cop_rst_o, 0);
        idle(1);       chk("R1 pulse one timeout after service", cop_rst_o, 1);
        idle(PULSE_LEN);
    endtask

    task automatic t_bad_service;
        int v;
        do_por(2'b10);
        wr(16'h001C, 8'h04);
        idle(5);
        wr(16'hFFF0, 8'h01);
        idle(TMO - 7); chk("R9 no pulse before timeout", cop_rst_o, 0);
        idle(1);       chk("R9 bit0=1 write did not service", cop_rst_o, 1);
        idle(PULSE_LEN);
        do_por(2'b10);
        wr(16'hFFF0, 8'h00);
        idle(TMO + 5);
        chk("R9 service while disabled no pulse", cop_rst_o, 0);
        rd(16'h001C, v); chk("R9 service while disabled no enable", v, 0);
    endtask

    task automatic t_terminal;
        do_por(2'b10);
        wr(16'h001C, 8'h04);
        idle(TMO - 1);
        wr(16'hFFF0, 8'h00);
        chk("R11 service on terminal edge wins", cop_rst_o, 0);
        idle(TMO - 1); chk("R11 new window not yet expired", cop_rst_o, 0);
        idle(1);       chk("R11 new window expires", cop_rst_o, 1);
        idle(PULSE_LEN);
    endtask

    task automatic t_mode;
        do_por(2'b10);
        chk("R7 mode from pin", mode_o, 2);
        mode_pin = 2'b01;
        wr(16'h001C, 8'h04);
        idle(TMO);
        chk("R6 pulse active", cop_rst_o, 1);
        chk("R6 mode kept during pulse", mode_o, 2);
        idle(PULSE_LEN);
        chk("R6 mode kept after pulse", mode_o, 2);
        do_por(2'b01);
        chk("R7 por reloads mode", mode_o, 1);
    endtask

    task automatic t_readback;
        int v;
        do_por(2'b10);
        wr(16'h001C, 8'hFB);
        rd(16'h001C, v); chk("R4 bit2=0 write does not enable", v, 0);
        wr(16'h001C, 8'hFF);
        rd(16'h001C, v); chk("R10 ctrl shows only bit 2", v, 4);
        rd(16'h001D, v); chk("R10 other address reads 0", v, 0);
        rd(16'hFFF0, v); chk("R10 service address reads 0", v, 0);
        idle(TMO + PULSE_LEN);
    endtask

    initial begin
        idle(1);
        t_reset_state();
        t_timeout();
        t_sticky();
        t_service();
        t_bad_service();
        t_terminal();
        t_mode();
        t_readback();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule